// File: doc/BRIEF.md
# Token-Gated Cycle Simulation Wrapper

This block puts a small synchronous target (a two-input adder feeding an accumulator) inside a token-driven shell. The target's clock runs all the time, but the target only moves forward one target cycle when a fire happens. A fire needs a token waiting in every input queue and free room in every output queue. On a fire the wrapper takes one token from each input queue, advances every target register through its hold multiplexer, and puts one token into each output queue. When there is no fire, every target register reloads its own value. Because of this, the number of host clock cycles has no effect on the target's behaviour.

Each of the four channels has its own circular trace buffer. A channel is an input token or an output token. Every fire writes the token values of that target cycle into these buffers, so the most recent window of channel activity can be read back to rebuild a replay. The fire logic runs a small controller with two states. GATE_RUN allows fires. GATE_HOLD blocks them and reports the stall. The controller moves from GATE_RUN to GATE_HOLD when a stall request (`hold_req`) or a trace read (`trc_rd`) is asserted. It returns to GATE_RUN in the cycle after both are low. A snapshot capture can therefore freeze the target, and trace read-out never races with trace writes.

Top module: `tgw_gate_wrap`

## Requirements
- R1: After reset, `cycle_count` is 0, `in_ready` is 2'b11, `out_valid` is 2'b00, `hold_ack` is 0 and `trc_fill` is 0.
- R2: No fire occurs and `cycle_count` does not change while either input token queue is empty.
- R3: No fire occurs while either output token queue is full. With inputs always available and no output pops, exactly FIFO_DEPTH fires happen, and then `out_valid` is 2'b11.
- R4: Each fire pops exactly one token per input, pushes exactly one token per output, and adds 1 to `cycle_count`. After draining, the fire count equals the smaller of the two input push counts, and each output has delivered that many tokens.
- R5: Output token k (counting from 0) carries the target outputs during target cycle k. Channel 1 (`out_data[2W-1:W]`) is s_k, where s_0 = 0 and s_k = a_{k-1} + b_{k-1}. Channel 0 (`out_data[W-1:0]`) is c_k, where c_0 = 0 and c_k = c_{k-1} + s_{k-1}. All sums are mod 2^W. Here a_i is input token i on `in_data[W-1:0]` and b_i is input token i on `in_data[2W-1:W]`. Token order is kept on every channel.
- R6: While `hold_req` is high, no fire occurs. `hold_ack` is 1 from the cycle after `hold_req` (or `trc_rd`) is seen high. It is 0 from the cycle after both are seen low.
- R7: `trc_fill` is min(fires, 2^TRACE_AW). With `trc_sel` = 0, 1, 2 or 3 (channel order: input a, input b, output c, output s), `trc_data` at `trc_idx` = i returns the value of that channel for fire number fires - trc_fill + i. Index 0 is the oldest entry kept.
- R8: While `trc_rd` is high, no fire occurs, and both the trace contents and `cycle_count` stay unchanged.
- R9: Each input queue accepts exactly FIFO_DEPTH tokens without a fire before it drops `in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Host offers a token on input channel i |
| in_ready | output | 2 | Input queue i has room |
| in_data | input | 2*DATA_W | Input tokens, channel i at [i*DATA_W +: DATA_W] |
| out_valid | output | 2 | Output queue j holds a token |
| out_ready | input | 2 | Host takes a token from output queue j |
| out_data | output | 2*DATA_W | Output tokens, channel j at [j*DATA_W +: DATA_W] |
| hold_req | input | 1 | Force a stall, for example during snapshot capture |
| hold_ack | output | 1 | Controller is in GATE_HOLD |
| cycle_count | output | CNT_W | Number of fires since reset |
| trc_rd | input | 1 | Trace read-out active; freezes the wrapper |
| trc_sel | input | 2 | Trace channel select |
| trc_idx | input | TRACE_AW | Trace entry index, 0 = oldest |
| trc_data | output | DATA_W | Selected trace entry |
| trc_fill | output | TRACE_AW+1 | Number of valid trace entries |

## Verification
The bench starves one input while the other is full. A wrapper that fires on partial tokens would advance `cycle_count` and would misalign the a/b pairing seen in later output values. It then blocks the outputs with no pops. A wrapper that ignores output space would overrun the queue and lose or reorder result tokens, so the fire count would no longer stop at the queue depth. Holds and trace reads are mixed into random traffic. Firing during either would change the trace between two reads, or make the count step under hold. Reading the trace before it wraps and after it wraps catches an oldest-entry pointer that is off by one.

// File: rtl/tgw_pkg.sv
package tgw_pkg;
    typedef enum logic [0:0] {
        GATE_RUN  = 1'b0,
        GATE_HOLD = 1'b1
    } gate_state_e;

    localparam int unsigned N_IN   = 2;
    localparam int unsigned N_OUT  = 2;
    localparam int unsigned N_CHAN = N_IN + N_OUT;
endpackage

// File: rtl/tgw_token_fifo.sv
module tgw_token_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_valid,
    output logic         push_ready,
    input  logic [W-1:0] push_data,
    output logic         pop_valid,
    input  logic         pop_ready,
    output logic [W-1:0] pop_data
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign push_ready = (cnt != CW'(DEPTH));
    assign pop_valid  = (cnt != '0);
    assign pop_data   = mem[rp];
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop_valid && pop_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end
endmodule

// File: rtl/tgw_target.sv
module tgw_target #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] out_acc,
    output logic [W-1:0] out_sum
);
    logic [W-1:0] sum_q, sum_d;
    logic [W-1:0] acc_q, acc_d;

    // hold multiplexers: without adv each register reloads itself
    always_comb begin
        sum_d = adv ? (in_a + in_b)  : sum_q;
        acc_d = adv ? (acc_q + sum_q) : acc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            acc_q <= '0;
        end else begin
            sum_q <= sum_d;
            acc_q <= acc_d;
        end
    end

    assign out_acc = acc_q;
    assign out_sum = sum_q;
endmodule

// File: rtl/tgw_trace_buf.sv
module tgw_trace_buf #(
    parameter int unsigned W  = 16,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    output logic [AW:0]   fill
);
    localparam int unsigned L = 1 << AW;

    logic [W-1:0]  mem [L];
    logic [AW-1:0] wp;
    logic [AW:0]   fill_q;
    logic [AW-1:0] rd_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp     <= '0;
            fill_q <= '0;
        end else if (wr_en) begin
            wp <= wp + 1'b1;
            if (fill_q != (AW+1)'(L)) fill_q <= fill_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    assign rd_addr = wp - fill_q[AW-1:0] + rd_idx;
    assign rd_data = mem[rd_addr];
    assign fill    = fill_q;
endmodule

// File: rtl/tgw_gate_wrap.sv
module tgw_gate_wrap
    import tgw_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned TRACE_AW   = 3,
    parameter int unsigned CNT_W      = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_IN-1:0]           in_valid,
    output logic [N_IN-1:0]           in_ready,
    input  logic [N_IN*DATA_W-1:0]    in_data,
    output logic [N_OUT-1:0]          out_valid,
    input  logic [N_OUT-1:0]          out_ready,
    output logic [N_OUT*DATA_W-1:0]   out_data,
    input  logic                      hold_req,
    output logic                      hold_ack,
    output logic [CNT_W-1:0]          cycle_count,
    input  logic                      trc_rd,
    input  logic [1:0]                trc_sel,
    input  logic [TRACE_AW-1:0]       trc_idx,
    output logic [DATA_W-1:0]         trc_data,
    output logic [TRACE_AW:0]         trc_fill
);
    gate_state_e state_q, state_d;

    logic [N_IN-1:0]   tok_avail;
    logic [N_OUT-1:0]  space;
    logic [DATA_W-1:0] tok_val [N_IN];
    logic [DATA_W-1:0] tgt_out [N_OUT];
    logic [DATA_W-1:0] chan_val [N_CHAN];
    logic [DATA_W-1:0] ch_rd [N_CHAN];
    logic [TRACE_AW:0] ch_fill [N_CHAN];
    logic              stall_all, tokens_ok, fire;
    logic [CNT_W-1:0]  cnt_q;

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        tgw_token_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) in_fifo_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_valid(in_valid[i]),
            .push_ready(in_ready[i]),
            .push_data (in_data[i*DATA_W +: DATA_W]),
            .pop_valid (tok_avail[i]),
            .pop_ready (fire),
            .pop_data  (tok_val[i])
        );
        assign chan_val[i] = tok_val[i];
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        tgw_token_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) out_fifo_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_valid(fire),
            .push_ready(space[j]),
            .push_data (tgt_out[j]),
            .pop_valid (out_valid[j]),
            .pop_ready (out_ready[j]),
            .pop_data  (out_data[j*DATA_W +: DATA_W])
        );
        assign chan_val[N_IN + j] = tgt_out[j];
    end

    tgw_target #(.W(DATA_W)) target_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (fire),
        .in_a   (tok_val[0]),
        .in_b   (tok_val[1]),
        .out_acc(tgt_out[0]),
        .out_sum(tgt_out[1])
    );

    for (genvar c = 0; c < N_CHAN; c++) begin : g_trc
        tgw_trace_buf #(.W(DATA_W), .AW(TRACE_AW)) trace_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (fire),
            .wr_data(chan_val[c]),
            .rd_idx (trc_idx),
            .rd_data(ch_rd[c]),
            .fill   (ch_fill[c])
        );
    end

    assign trc_data  = ch_rd[trc_sel];
    assign trc_fill  = ch_fill[trc_sel];
    assign stall_all = hold_req || trc_rd;
    assign tokens_ok = (&tok_avail) && (&space);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_RUN;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        fire     = 1'b0;
        hold_ack = 1'b0;
        unique case (state_q)
            GATE_RUN: begin
                fire = !stall_all && tokens_ok;
                if (stall_all) state_d = GATE_HOLD;
            end
            GATE_HOLD: begin
                hold_ack = 1'b1;
                if (!stall_all) state_d = GATE_RUN;
            end
            default: state_d = GATE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (fire) cnt_q <= cnt_q + 1'b1;
    end

    assign cycle_count = cnt_q;
endmodule

// File: rtl/tgw_gate_chk.sv
module tgw_gate_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fire,
    input logic [1:0]       tok_avail,
    input logic [1:0]       space,
    input logic             hold_req,
    input logic             trc_rd,
    input logic             hold_ack,
    input logic [CNT_W-1:0] cycle_count
);
    // R2
    in_token_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (&tok_avail));
    // R3
    out_space_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (&space));
    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cycle_count == $past(cycle_count) + 1'b1);
    // R4
    count_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(cycle_count));
    // R6
    hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |-> !fire);
    // R6
    hold_ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req || trc_rd) |=> hold_ack);
    // R6
    hold_ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_req && !trc_rd) |=> !hold_ack);
    // R8
    trace_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trc_rd |-> !fire);
endmodule

bind tgw_gate_wrap tgw_gate_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .tok_avail  (tok_avail),
    .space      (space),
    .hold_req   (hold_req),
    .trc_rd     (trc_rd),
    .hold_ack   (hold_ack),
    .cycle_count(cycle_count)
);

// File: tb/tgw_gate_wrap_tb_top.sv
`timescale 1ns/1ps
module tgw_gate_wrap_tb_top;
    localparam int W  = 16;
    localparam int FD = 4;
    localparam int AW = 3;
    localparam int L  = 1 << AW;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    in_valid = '0;
    logic [1:0]    in_ready;
    logic [2*W-1:0] in_data = '0;
    logic [1:0]    out_valid;
    logic [1:0]    out_ready = '0;
    logic [2*W-1:0] out_data;
    logic          hold_req = 1'b0;
    logic          hold_ack;
    logic [CW-1:0] cycle_count;
    logic          trc_rd = 1'b0;
    logic [1:0]    trc_sel = '0;
    logic [AW-1:0] trc_idx = '0;
    logic [W-1:0]  trc_data;
    logic [AW:0]   trc_fill;

    always #2.5 clk = ~clk;

    tgw_gate_wrap #(.DATA_W(W), .FIFO_DEPTH(FD), .TRACE_AW(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .hold_req(hold_req), .hold_ack(hold_ack), .cycle_count(cycle_count),
        .trc_rd(trc_rd), .trc_sel(trc_sel), .trc_idx(trc_idx),
        .trc_data(trc_data), .trc_fill(trc_fill)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] a_hist [8192];
    logic [W-1:0] b_hist [8192];
    logic [W-1:0] es [8192];
    logic [W-1:0] ec [8192];
    int na = 0, nb = 0, nk = 0;
    int nout [2] = '{0, 0};

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected s_k and c_k of output token k, built from the input history
    task automatic extend(input int k);
        while (nk <= k) begin
            if (nk == 0) begin
                es[0] = '0;
                ec[0] = '0;
            end else begin
                es[nk] = a_hist[nk-1] + b_hist[nk-1];
                ec[nk] = ec[nk-1] + es[nk-1];
            end
            nk++;
        end
    endtask

    function automatic int imin(input int x, input int y);
        return (x < y) ? x : y;
    endfunction

    task automatic run(input int n, input int pa, input int pb, input int po, input int ph);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            for (int j = 0; j < 2; j++) begin
                logic r;
                r = (($urandom % 100) < po);
                out_ready[j] = r;
                if (out_valid[j] && r) begin
                    logic [W-1:0] got, exp;
                    extend(nout[j]);
                    got = out_data[j*W +: W];
                    exp = (j == 0) ? ec[nout[j]] : es[nout[j]];
                    chk(got == exp, "R5 output token", got, exp);
                    nout[j]++;
                end
            end
            in_valid[0] = (($urandom % 100) < pa);
            in_valid[1] = (($urandom % 100) < pb);
            in_data = {W'($urandom), W'($urandom)};
            if (in_valid[0] && in_ready[0]) begin a_hist[na] = in_data[W-1:0];   na++; end
            if (in_valid[1] && in_ready[1]) begin b_hist[nb] = in_data[2*W-1:W]; nb++; end
            hold_req = (($urandom % 100) < ph);
        end
        @(negedge clk);
        in_valid  = '0;
        out_ready = '0;
        if (ph < 100) hold_req = 1'b0;
    endtask

    function automatic logic [W-1:0] trace_exp(input int ch, input int f);
        case (ch)
            0: return a_hist[f];
            1: return b_hist[f];
            2: return ec[f];
            default: return es[f];
        endcase
    endfunction

    initial begin
        #(5ns * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cycle_count == 0, "R1 count", cycle_count, 0);
        chk(in_ready == 2'b11, "R1 in_ready", in_ready, 3);
        chk(out_valid == 2'b00, "R1 out_valid", out_valid, 0);
        chk(hold_ack == 1'b0, "R1 hold_ack", hold_ack, 0);
        chk(trc_fill == 0, "R1 trc_fill", trc_fill, 0);

        // R2: only input a fed; R9: a accepts exactly FD tokens
        run(20, 100, 0, 100, 0);
        repeat (3) @(negedge clk);
        chk(cycle_count == 0, "R2 starved count", cycle_count, 0);
        chk(out_valid == 2'b00, "R2 no outputs", out_valid, 0);
        chk(na == FD, "R9 accepted depth", na, FD);
        chk(in_ready[0] == 1'b0, "R9 in_ready low when full", in_ready[0], 0);

        // R3: outputs never popped, stop after FD fires
        run(30, 100, 100, 0, 0);
        repeat (3) @(negedge clk);
        chk(cycle_count == FD, "R3 fires bounded by output space", cycle_count, FD);
        chk(out_valid == 2'b11, "R3 outputs full", out_valid, 3);

        // R7 before wrap
        trc_rd = 1'b1;
        trc_sel = 2'd0;
        trc_idx = '0;
        #1;
        chk(trc_fill == FD, "R7 fill before wrap", trc_fill, FD);
        chk(trc_data == a_hist[0], "R7 oldest entry before wrap", trc_data, a_hist[0]);
        @(negedge clk);
        trc_rd = 1'b0;

        // R6 hold
        @(negedge clk);
        hold_req = 1'b1;
        @(negedge clk);
        chk(hold_ack == 1'b1, "R6 hold_ack rise", hold_ack, 1);
        run(20, 100, 100, 100, 100);
        repeat (2) @(negedge clk);
        chk(cycle_count == FD, "R6 no fire under hold", cycle_count, FD);
        hold_req = 1'b0;
        @(negedge clk);
        chk(hold_ack == 1'b0, "R6 hold_ack fall", hold_ack, 0);

        // random traffic with sporadic holds, then drain
        run(3000, 60, 70, 50, 10);
        run(100, 0, 0, 100, 0);
        repeat (3) @(negedge clk);
        chk(cycle_count == imin(na, nb), "R4 fires equal min input tokens", cycle_count, imin(na, nb));
        chk(nout[0] == cycle_count, "R4 output 0 tokens", nout[0], cycle_count);
        chk(nout[1] == cycle_count, "R4 output 1 tokens", nout[1], cycle_count);

        // R7 after wrap
        trc_rd = 1'b1;
        begin
            int f0;
            f0 = int'(cycle_count) - L;
            extend(int'(cycle_count));
            #1;
            chk(trc_fill == L, "R7 fill saturates", trc_fill, L);
            for (int ch = 0; ch < 4; ch++) begin
                for (int i = 0; i < L; i++) begin
                    trc_sel = 2'(ch);
                    trc_idx = AW'(i);
                    #0.2;
                    chk(trc_data == trace_exp(ch, f0 + i), "R7 trace entry", trc_data, trace_exp(ch, f0 + i));
                end
            end
            // R8 freeze during read
            begin
                logic [CW-1:0] c0;
                c0 = cycle_count;
                trc_sel = 2'd3;
                trc_idx = AW'(L - 1);
                run(20, 100, 100, 100, 0);
                repeat (2) @(negedge clk);
                chk(cycle_count == c0, "R8 count frozen during trace read", cycle_count, c0);
                chk(trc_data == trace_exp(3, f0 + L - 1), "R8 trace unchanged", trc_data, trace_exp(3, f0 + L - 1));
                chk(trc_fill == L, "R8 fill unchanged", trc_fill, L);
            end
        end
        trc_rd = 1'b0;
        run(60, 0, 0, 100, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule